// File: doc/BRIEF.md
# Two-Wire Bus Control Byte Decoder

This block watches a two-wire serial bus, with a clock line and a data line, on behalf of a small serial memory. After each Start condition it collects the first byte that the bus master sends. It checks that byte against a fixed device-type code and the chip-select straps. When the byte addresses this device, the block pulls the data line low for the acknowledge clock. It also reports whether the master asked for a read or a write, and which upper word-address bits the chip-select field carried.

The bus lines arrive asynchronously. They are brought into the system clock domain, and Start, Stop and clock edges are detected there. Three straps set how the chip-select field is judged:
- **Pin compare:** all three select bits are compared with the address pins.
- **Don't-care:** the select bits are ignored.
- **Small package:** the top select pin does not exist, so the top select bit must be zero and only the lower two bits are compared with pins.

Handling of the word address, storage and data transfer are left to neighbouring logic.

Top module: `ctrl_byte_decoder`

## Requirements
- R1: After reset, sdaPullLow, matchPulse and readNotWrite are 0 and upperAddr is 3'b000.
- R2: Control byte bits are sampled MSB first on rising SCL edges. Bits 7:4 must equal 4'b1010 or the byte is not acknowledged.
- R3: With selIgnore=0 and smallPkg=0, bits 3:1 of the byte (bit 3 = A2, bit 2 = A1, bit 1 = A0) must equal addrPins[2:0] for a match.
- R4: With selIgnore=1, bits 3:1 are ignored and any value matches once the code matches. selIgnore takes priority over smallPkg.
- R5: With smallPkg=1 and selIgnore=0, bit 3 must be 0, and bits 2:1 must equal addrPins[1:0]. addrPins[2] is ignored.
- R6: Bit 0 of a matching byte selects the operation (1 = read, 0 = write). It is presented on readNotWrite and held until the next match.
- R7: On a match, sdaPullLow rises after the 8th falling SCL edge of the byte and falls after the 9th falling edge.
- R8: On a match, upperAddr takes {bit3, bit2, bit1}, which are word-address bits 10, 9 and 8. It is held until the next match.
- R9: matchPulse is high for exactly one clock cycle per matching byte.
- R10: On a mismatch there is no acknowledge, no pulse, and readNotWrite and upperAddr keep their values. Further bytes are ignored until the next Start. A matched transfer also ignores later bytes until a new Start.
- R11: A Start (SDA falling while SCL high) restarts byte collection, even in the middle of a byte. A Stop (SDA rising while SCL high) releases SDA and ignores the bus until the next Start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line, asynchronous |
| sdaIn | input | 1 | Bus data line, asynchronous |
| addrPins | input | 3 | Chip-select strap pins, [2] = A2 |
| selIgnore | input | 1 | 1 = chip-select bits are don't-care |
| smallPkg | input | 1 | 1 = no A2 pin, select bit A2 must be 0 |
| sdaPullLow | output | 1 | Enable for the open-drain pull-down on SDA |
| matchPulse | output | 1 | One-cycle pulse when a control byte matches |
| readNotWrite | output | 1 | Operation of the last matching byte, 1 = read |
| upperAddr | output | 3 | Word-address bits 10:8 of the last matching byte |

## Verification
A wrong state in the decoder shows up at the ports within the next bus byte.

- **Bit counter:** an off-by-one count shifts the acknowledge window by a whole SCL period. It also misaligns the select field, so addresses that should match are refused and the reverse.
- **State machine stuck in the acknowledge or skip state:** after a new Start the next valid byte gets no acknowledge and no pulse.
- **Missed Start or Stop detection:** bytes sent without a fresh Start are acknowledged, which the bench watches for after both mismatched and matched transfers.
- **Mode decode mixed up:** a single byte per strap setting exposes it through the acknowledge and the captured upperAddr value.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  localparam int CODE_W    = 4;
  localparam int CS_W      = 3;
  localparam int BYTE_BITS = CODE_W + CS_W + 1;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);

  typedef struct packed {
    logic clrBits;
    logic shiftBit;
    logic capture;
  } cbdStrobes_t;

  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic sclRise;
    logic sclFall;
    logic byteFull;
    logic addrHit;
  } cbdEvents_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_ACK   = 2'd2,
    ST_SKIP  = 2'd3
  } cbdState_t;
endpackage

// File: rtl/cbd_sync.sv
module cbd_sync #(
  parameter int   STAGES   = 2,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic qOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], dIn};
  end

  assign qOut = chain[STAGES-1];
endmodule

// File: rtl/cbd_datapath.sv
module cbd_datapath
  import cbd_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] DEV_CODE   = 4'b1010
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [CS_W-1:0]  addrPins,
  input  logic             selIgnore,
  input  logic             smallPkg,
  input  cbdStrobes_t      strobes,
  output cbdEvents_t       events,
  output logic             readNotWrite,
  output logic [CS_W-1:0]  upperAddr
);
  localparam int CS_LSB   = 1;
  localparam int CS_MSB   = CS_LSB + CS_W - 1;
  localparam int CODE_LSB = CS_MSB + 1;

  logic sclS, sdaS, sclD, sdaD;
  logic [BYTE_BITS-1:0] shiftReg;
  logic [CNT_W-1:0]     bitCnt;
  logic codeOk, csOk;

  cbd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclSync (
    .clk(clk), .rstN(rstN), .dIn(sclIn), .qOut(sclS)
  );
  cbd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sdaSync (
    .clk(clk), .rstN(rstN), .dIn(sdaIn), .qOut(sdaS)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobes.clrBits) begin
      bitCnt   <= '0;
    end else if (strobes.shiftBit) begin
      shiftReg <= {shiftReg[BYTE_BITS-2:0], sdaS};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  assign codeOk = (shiftReg[CODE_LSB +: CODE_W] == DEV_CODE);

  always_comb begin
    if (selIgnore)
      csOk = 1'b1;
    else if (smallPkg)
      csOk = !shiftReg[CS_MSB] &&
             (shiftReg[CS_MSB-1:CS_LSB] == addrPins[CS_W-2:0]);
    else
      csOk = (shiftReg[CS_MSB:CS_LSB] == addrPins);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readNotWrite <= 1'b0;
      upperAddr    <= '0;
    end else if (strobes.capture) begin
      readNotWrite <= shiftReg[0];
      upperAddr    <= shiftReg[CS_MSB:CS_LSB];
    end
  end

  always_comb begin
    events.startDet = sclS && sclD && sdaD && !sdaS;
    events.stopDet  = sclS && sclD && !sdaD && sdaS;
    events.sclRise  = sclS && !sclD;
    events.sclFall  = !sclS && sclD;
    events.byteFull = (bitCnt == CNT_W'(BYTE_BITS));
    events.addrHit  = codeOk && csOk;
  end

  AST_CODE_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> shiftReg[CODE_LSB +: CODE_W] == DEV_CODE); // R2
  AST_PINS_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture && !selIgnore && !smallPkg |-> shiftReg[CS_MSB:CS_LSB] == addrPins); // R3
  AST_SMALL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture && !selIgnore && smallPkg |-> !shiftReg[CS_MSB]); // R5
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_BITS)); // R2
  AST_CAPTURE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> events.byteFull); // R7
endmodule

// File: rtl/cbd_control.sv
module cbd_control
  import cbd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  cbdEvents_t  events,
  output cbdStrobes_t strobes,
  output logic        sdaPullLow,
  output logic        matchPulse
);
  cbdState_t state, stateNext;
  logic pullNext;

  always_comb begin
    stateNext = state;
    pullNext  = sdaPullLow;
    strobes   = '0;
    if (events.startDet) begin
      stateNext       = ST_SHIFT;
      pullNext        = 1'b0;
      strobes.clrBits = 1'b1;
    end else if (events.stopDet) begin
      stateNext = ST_IDLE;
      pullNext  = 1'b0;
    end else begin
      unique case (state)
        ST_SHIFT: begin
          if (events.sclRise && !events.byteFull)
            strobes.shiftBit = 1'b1;
          if (events.sclFall && events.byteFull) begin
            if (events.addrHit) begin
              stateNext       = ST_ACK;
              pullNext        = 1'b1;
              strobes.capture = 1'b1;
            end else begin
              stateNext = ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (events.sclFall) begin
            stateNext = ST_SKIP;
            pullNext  = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      sdaPullLow <= 1'b0;
      matchPulse <= 1'b0;
    end else begin
      state      <= stateNext;
      sdaPullLow <= pullNext;
      matchPulse <= strobes.capture;
    end
  end

  AST_ACK_WITH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> matchPulse); // R7
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> !matchPulse); // R9
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    events.startDet |=> !sdaPullLow); // R11
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    events.stopDet |=> !sdaPullLow && state == ST_IDLE); // R11
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SKIP && !events.startDet |=> !matchPulse); // R10
endmodule

// File: rtl/ctrl_byte_decoder.sv
module ctrl_byte_decoder
  import cbd_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] DEV_CODE   = 4'b1010
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclIn,
  input  logic            sdaIn,
  input  logic [CS_W-1:0] addrPins,
  input  logic            selIgnore,
  input  logic            smallPkg,
  output logic            sdaPullLow,
  output logic            matchPulse,
  output logic            readNotWrite,
  output logic [CS_W-1:0] upperAddr
);
  cbdStrobes_t strobes;
  cbdEvents_t  events;

  cbd_datapath #(.SYNC_STAGES(SYNC_STAGES), .DEV_CODE(DEV_CODE)) u_datapath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrPins(addrPins), .selIgnore(selIgnore), .smallPkg(smallPkg),
    .strobes(strobes), .events(events),
    .readNotWrite(readNotWrite), .upperAddr(upperAddr)
  );

  cbd_control u_control (
    .clk(clk), .rstN(rstN), .events(events), .strobes(strobes),
    .sdaPullLow(sdaPullLow), .matchPulse(matchPulse)
  );
endmodule

// File: tb/test_ctrl_byte_decoder.sv
module test_ctrl_byte_decoder;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] addrPins = 3'b000;
  logic selIgnore = 1'b0;
  logic smallPkg = 1'b0;
  logic sdaPullLow, matchPulse, readNotWrite;
  logic [2:0] upperAddr;
  logic sdaBus;

  int errors = 0;
  int checks = 0;
  int pulseCnt = 0;
  bit done = 1'b0;
  logic expRnw = 1'b0;
  logic [2:0] expUpper = 3'b000;

  always #2 clk = ~clk;

  assign sdaBus = sdaM & ~sdaPullLow;

  ctrl_byte_decoder i_ctrl_byte_decoder (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .addrPins(addrPins), .selIgnore(selIgnore), .smallPkg(smallPkg),
    .sdaPullLow(sdaPullLow), .matchPulse(matchPulse),
    .readNotWrite(readNotWrite), .upperAddr(upperAddr)
  );

  always @(negedge clk) if (rstN && matchPulse) pulseCnt++;

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitClk(H);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b0; waitClk(2);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b1; waitClk(H);
  endtask

  task automatic sendBit(input logic b);
    waitClk(2);
    sdaM = b; waitClk(H);
    sclM = 1'b1; waitClk(H);
    sclM = 1'b0;
  endtask

  // Sends 8 bits plus the acknowledge clock and checks ack, pulse and outputs.
  task automatic sendByte(input logic [7:0] b, input bit expAck, input string tag);
    int p0;
    p0 = pulseCnt;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    waitClk(2);
    sdaM = 1'b1;
    waitClk(H / 2);
    check(sdaPullLow == expAck, {tag, " R7 ack after 8th fall"}, sdaPullLow, expAck);
    waitClk(H - H / 2);
    sclM = 1'b1; waitClk(H);
    sclM = 1'b0; waitClk(7);
    check(sdaPullLow == 1'b0, {tag, " R7 release after 9th fall"}, sdaPullLow, 0);
    check(pulseCnt - p0 == int'(expAck), {tag, " R9 pulse count"}, pulseCnt - p0, int'(expAck));
    if (expAck) begin
      expRnw = b[0];
      expUpper = b[3:1];
    end
    check(readNotWrite == expRnw, {tag, " R6 readNotWrite"}, readNotWrite, expRnw);
    check(upperAddr == expUpper, {tag, " R8 upperAddr"}, upperAddr, expUpper);
  endtask

  task automatic testReset();
    check(sdaPullLow == 0 && matchPulse == 0, "R1 reset pull/pulse", sdaPullLow, 0);
    check(readNotWrite == 0 && upperAddr == 0, "R1 reset rnw/upper", upperAddr, 0);
  endtask

  task automatic testPinMode();
    addrPins = 3'b101; selIgnore = 0; smallPkg = 0;
    startCond(); sendByte(8'b1010_101_1, 1, "R3 pin read"); stopCond();
    startCond(); sendByte(8'b1010_101_0, 1, "R3 pin write"); stopCond();
    startCond(); sendByte(8'b1010_100_1, 0, "R3 pin mismatch"); stopCond();
    addrPins = 3'b010;
    startCond(); sendByte(8'b1010_010_1, 1, "R3 pin other address"); stopCond();
  endtask

  task automatic testWrongCode();
    addrPins = 3'b101; selIgnore = 0; smallPkg = 0;
    startCond(); sendByte(8'b1011_101_1, 0, "R2 bad code"); stopCond();
    startCond(); sendByte(8'b0101_101_0, 0, "R2 reversed code"); stopCond();
  endtask

  task automatic testIgnoreAfterMiss();
    addrPins = 3'b011; selIgnore = 0; smallPkg = 0;
    startCond();
    sendByte(8'b1010_000_0, 0, "R10 mismatch");
    sendByte(8'b1010_011_0, 0, "R10 valid byte without start after miss");
    startCond();
    sendByte(8'b1010_011_1, 1, "R10 valid after new start");
    sendByte(8'b1010_011_0, 0, "R10 second byte after match");
    stopCond();
  endtask

  task automatic testDontCare();
    addrPins = 3'b000; selIgnore = 1; smallPkg = 0;
    startCond(); sendByte(8'b1010_110_1, 1, "R4 dont care 110"); stopCond();
    smallPkg = 1;
    startCond(); sendByte(8'b1010_111_0, 1, "R4 dont care over small pkg"); stopCond();
    startCond(); sendByte(8'b1110_111_0, 0, "R4 dont care bad code"); stopCond();
  endtask

  task automatic testSmallPkg();
    addrPins = 3'b110; selIgnore = 0; smallPkg = 1;
    startCond(); sendByte(8'b1010_010_0, 1, "R5 small match pin2 ignored"); stopCond();
    startCond(); sendByte(8'b1010_110_1, 0, "R5 small top bit set"); stopCond();
    startCond(); sendByte(8'b1010_011_1, 0, "R5 small low bits differ"); stopCond();
  endtask

  task automatic testRestart();
    addrPins = 3'b001; selIgnore = 0; smallPkg = 0;
    startCond();
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    startCond();
    sendByte(8'b1010_001_1, 1, "R11 repeated start mid byte");
    stopCond();
    check(sdaPullLow == 0, "R11 released after stop", sdaPullLow, 0);
    sclM = 1'b0; waitClk(2);
    sendByte(8'b1010_001_0, 0, "R11 byte after stop without start");
    stopCond();
  endtask

  initial begin
    waitClk(5);
    testReset();
    rstN = 1'b1;
    waitClk(5);
    testReset();
    testPinMode();
    testWrongCode();
    testIgnoreAfterMiss();
    testDontCare();
    testSmallPkg();
    testRestart();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule